// File: doc/BRIEF.md
# Debug-State Exception Level Raise Unit

This block handles one system instruction that is legal only while the core is halted for external debug. When a matching instruction word arrives with its valid strobe, the block does one of two things. It raises an undefined-instruction trap. Or it moves the processing element to a higher exception level, selects that level's own stack pointer and picks up the data endianness configured for that level.

The block owns three pieces of architectural state: the current exception level, the stack-pointer select and the data endianness. The rest of the core can overwrite the level and the stack-pointer select through a write port, as exception entry and return would. When an execute succeeds, the block also pulses strobes that tell the register files to treat the target level's link, saved-status and syndrome registers as unknown, together with the debug link and debug saved-status registers.

Every result is registered. A trap or a commit appears as a one-cycle pulse in the cycle after the valid strobe.

Top module: `dbg_el_raise`

## Requirements
- R1: An instruction is recognised only when word bits [31:21] equal 11'b11010100101 and bits [4:0] equal 5'b00010. Bits [20:5] are an immediate with no effect. A valid word that does not match raises no trap, no commit and no clobber, and leaves all state unchanged.
- R2: A matching instruction received while `halted` is 0 raises `undef_trap` and changes no state.
- R3: A matching instruction received while `el2_present` is 0 raises `undef_trap` at every level.
- R4: A matching instruction received while `el2_enabled` is 0 raises `undef_trap` when the current level is 2'b00 or 2'b01. At 2'b10 or 2'b11 it still commits.
- R5: On a commit from level 2'b00 or 2'b01, `cur_el` becomes 2'b10. On a commit from 2'b10 or 2'b11, `cur_el` keeps its value. In both cases `sp_dedicated` becomes 1.
- R6: After a commit, `big_endian` equals `endian_cfg[t]`, where t is the target level: 3 when executing at 2'b11, 2 otherwise. `clobber_el` reports t.
- R7: A commit pulses `clobber_elr`, `clobber_spsr`, `clobber_esr` and `clobber_dbg` high for exactly that cycle. No clobber strobe is high without `commit`.
- R8: `undef_trap` and `commit` are each high for one cycle, in the cycle after the valid strobe, and are never high together.
- R9: While reset is active, `cur_el` is 2'b11, `sp_dedicated` is 1, `big_endian` is 0 and all pulses are low.
- R10: `lvl_wr` loads `cur_el` from `lvl_wdata` and `sp_dedicated` from `sp_wdata` on the next edge, unless a commit happens on that same edge, in which case the commit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word valid |
| insn | input | 32 | Instruction word |
| halted | input | 1 | Core is in debug (halted) state |
| el2_present | input | 1 | EL2 is implemented |
| el2_enabled | input | 1 | EL2 enabled in the current security state |
| endian_cfg | input | 4 | Per-level big-endian control bit, indexed by level |
| lvl_wr | input | 1 | Load level and stack-pointer select |
| lvl_wdata | input | 2 | Level value to load |
| sp_wdata | input | 1 | Stack-pointer select to load |
| cur_el | output | 2 | Current exception level |
| sp_dedicated | output | 1 | 1: per-level stack pointer, 0: EL0 stack pointer |
| big_endian | output | 1 | Data endianness, 1 = big |
| undef_trap | output | 1 | Undefined-instruction pulse |
| commit | output | 1 | Successful execute pulse |
| clobber_el | output | 2 | Level whose registers are clobbered |
| clobber_elr | output | 1 | Link register becomes unknown |
| clobber_spsr | output | 1 | Saved status register becomes unknown |
| clobber_esr | output | 1 | Syndrome register becomes unknown |
| clobber_dbg | output | 1 | Debug link and debug saved status become unknown |

## Verification
The assertions check on every cycle that trap and commit exclude each other, that clobber strobes travel only with a commit, that a commit always leaves the level at 2 or 3 with the dedicated pointer selected, and that a trap leaves level and endianness untouched. Some behaviour appears only in the bench's scenarios: the exact decode boundary against near-miss words, the choice among the trap conditions for each combination of level and configuration, and the endianness bit chosen per target level. The bench compares every output against its behavioural model on every clock.

// File: rtl/dbg_el_raise.sv
module dbg_el_raise (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [31:0] insn,
  input  logic        halted,
  input  logic        el2_present,
  input  logic        el2_enabled,
  input  logic [3:0]  endian_cfg,
  input  logic        lvl_wr,
  input  logic [1:0]  lvl_wdata,
  input  logic        sp_wdata,
  output logic [1:0]  cur_el,
  output logic        sp_dedicated,
  output logic        big_endian,
  output logic        undef_trap,
  output logic        commit,
  output logic [1:0]  clobber_el,
  output logic        clobber_elr,
  output logic        clobber_spsr,
  output logic        clobber_esr,
  output logic        clobber_dbg
);
  localparam logic [10:0] OPC_HI = 11'b11010100101;
  localparam logic [4:0]  OPC_LO = 5'b00010;

  logic       hit, low_el, refuse, go;
  logic [1:0] tgt;

  assign hit    = insn_valid && insn[31:21] == OPC_HI && insn[4:0] == OPC_LO;
  assign low_el = cur_el < 2'd2;
  assign refuse = !halted || !el2_present || (!el2_enabled && low_el);
  assign go     = hit && !refuse;
  assign tgt    = (cur_el == 2'd3) ? 2'd3 : 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_el       <= 2'd3;
      sp_dedicated <= 1'b1;
      big_endian   <= 1'b0;
      undef_trap   <= 1'b0;
      commit       <= 1'b0;
      clobber_el   <= 2'd0;
    end else begin
      undef_trap <= hit && refuse;
      commit     <= go;
      if (go) begin
        cur_el       <= tgt;
        sp_dedicated <= 1'b1;
        big_endian   <= endian_cfg[tgt];
        clobber_el   <= tgt;
      end else if (lvl_wr) begin
        cur_el       <= lvl_wdata;
        sp_dedicated <= sp_wdata;
      end
    end
  end

  assign clobber_elr  = commit;
  assign clobber_spsr = commit;
  assign clobber_esr  = commit;
  assign clobber_dbg  = commit;
endmodule

module dbg_el_raise_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       insn_valid,
  input logic       halted,
  input logic       lvl_wr,
  input logic [1:0] cur_el,
  input logic       sp_dedicated,
  input logic       big_endian,
  input logic       undef_trap,
  input logic       commit,
  input logic       clobber_elr,
  input logic       clobber_spsr,
  input logic       clobber_esr,
  input logic       clobber_dbg
);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(undef_trap && commit));

  a_r8_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !undef_trap && !commit);

  a_r2_not_halted: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && !halted |=> !commit);

  a_r5_commit_state: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> cur_el[1] && sp_dedicated);

  a_r7_clobber_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (clobber_elr || clobber_spsr || clobber_esr || clobber_dbg) |-> commit);

  a_r7_all_clobbers: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> clobber_elr && clobber_spsr && clobber_esr && clobber_dbg);

  a_r2_trap_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    undef_trap && !$past(lvl_wr) && $past(rst_n) |-> $stable(cur_el) && $stable(big_endian) && $stable(sp_dedicated));
endmodule

bind dbg_el_raise dbg_el_raise_chk u_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .halted(halted),
  .lvl_wr(lvl_wr), .cur_el(cur_el), .sp_dedicated(sp_dedicated),
  .big_endian(big_endian), .undef_trap(undef_trap), .commit(commit),
  .clobber_elr(clobber_elr), .clobber_spsr(clobber_spsr),
  .clobber_esr(clobber_esr), .clobber_dbg(clobber_dbg)
);

// File: tb/sim_dbg_el_raise.sv
module sim_dbg_el_raise;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_valid = 1'b0;
  logic [31:0] insn = 32'd0;
  logic halted = 1'b0, el2_present = 1'b1, el2_enabled = 1'b1;
  logic [3:0] endian_cfg = 4'd0;
  logic lvl_wr = 1'b0;
  logic [1:0] lvl_wdata = 2'd0;
  logic sp_wdata = 1'b0;
  logic [1:0] cur_el, clobber_el;
  logic sp_dedicated, big_endian, undef_trap, commit;
  logic clobber_elr, clobber_spsr, clobber_esr, clobber_dbg;

  dbg_el_raise u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string req = "R9";

  int m_el = 3, m_sp = 1, m_be = 0, m_trap = 0, m_com = 0, m_cel = 0;

  function automatic logic [31:0] mk(input int imm);
    return {11'b11010100101, imm[15:0], 5'b00010};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_el = 3; m_sp = 1; m_be = 0; m_trap = 0; m_com = 0; m_cel = 0;
    end else begin
      bit is_ours, bad;
      int t;
      is_ours = insn_valid && (insn[31:21] == 11'h6A5) && (insn[4:0] == 5'd2);
      bad = (halted == 0) || (el2_present == 0) || (el2_enabled == 0 && m_el <= 1);
      t = (m_el == 3) ? 3 : 2;
      m_trap = (is_ours && bad) ? 1 : 0;
      m_com  = (is_ours && !bad) ? 1 : 0;
      if (m_com == 1) begin
        m_el = t; m_sp = 1; m_be = endian_cfg[t]; m_cel = t;
      end else if (lvl_wr) begin
        m_el = lvl_wdata; m_sp = sp_wdata;
      end
    end
  end

  task automatic cmp(input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp("cur_el", cur_el, m_el);
    cmp("sp_dedicated", sp_dedicated, m_sp);
    cmp("big_endian", big_endian, m_be);
    cmp("undef_trap", undef_trap, m_trap);
    cmp("commit", commit, m_com);
    cmp("clobber_elr", clobber_elr, m_com);
    cmp("clobber_spsr", clobber_spsr, m_com);
    cmp("clobber_esr", clobber_esr, m_com);
    cmp("clobber_dbg", clobber_dbg, m_com);
    if (m_com == 1) cmp("clobber_el", clobber_el, m_cel);
  end

  task automatic step(input bit v, input logic [31:0] w);
    @(posedge clk); #1;
    insn_valid = v; insn = w; lvl_wr = 1'b0;
  endtask

  task automatic set_lvl(input int l, input bit s);
    @(posedge clk); #1;
    insn_valid = 1'b0; lvl_wr = 1'b1; lvl_wdata = l[1:0]; sp_wdata = s;
  endtask

  task automatic idle();
    step(1'b0, 32'd0);
  endtask

  task automatic finish_up();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_up();
    end
  end

  initial begin
    endian_cfg = 4'b1000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle();

    req = "R2";
    halted = 0; step(1, mk(0)); idle(); idle();

    req = "R1";
    halted = 1;
    step(1, mk(0) ^ 32'h0000_0001); step(1, mk(0) ^ 32'h0000_0004);
    step(1, mk(0) ^ 32'h0020_0000); step(1, mk(0) ^ 32'h8000_0000);
    step(0, mk(0)); idle();

    req = "R6";
    step(1, mk(16'hBEEF)); idle();

    req = "R5";
    set_lvl(1, 0); idle();
    step(1, mk(1)); idle();
    set_lvl(0, 0); step(1, mk(16'hFFFF)); idle();

    req = "R4";
    el2_enabled = 0; set_lvl(0, 0); step(1, mk(0)); idle();
    set_lvl(1, 0); step(1, mk(0)); idle();
    set_lvl(2, 0); endian_cfg = 4'b0100; step(1, mk(0)); idle();
    set_lvl(3, 0); endian_cfg = 4'b0000; step(1, mk(0)); idle();

    req = "R3";
    el2_enabled = 1; el2_present = 0;
    step(1, mk(0)); set_lvl(2, 1); step(1, mk(0)); set_lvl(0, 0); step(1, mk(0)); idle();

    req = "R8";
    el2_present = 1; endian_cfg = 4'b1111;
    step(1, mk(3)); step(1, mk(4)); step(1, mk(5)); idle();
    halted = 0; step(1, mk(6)); halted = 1; step(1, mk(7)); idle();

    req = "R10";
    set_lvl(1, 1); idle();
    @(posedge clk); #1;
    insn_valid = 1; insn = mk(0); lvl_wr = 1; lvl_wdata = 2'd0; sp_wdata = 0;
    idle(); idle();

    req = "R7";
    set_lvl(0, 0); step(1, mk(9)); idle(); idle();

    req = "R9";
    rst_n = 0; step(1, mk(0)); idle();
    rst_n = 1; idle(); idle();

    finish_up();
  end
endmodule